// File: doc/BRIEF.md
# Adaptive Binary Context State Manager

This block keeps the adaptive probability state used by a binary arithmetic coder. Nineteen coding contexts each own a most-probable-symbol bit and a six-bit position in a fixed 47-state transition table. A decision bit arrives together with its 5-bit context number and the coder's current 16-bit interval register value. The block fetches the context's state and looks up that state's table row, which holds the probability estimate, the next state after an MPS, the next state after an LPS, and a swap flag. It classifies the decision as an MPS or LPS event, reports the probability estimate and whether the interval must renormalize, and writes the adapted state back into the context store.

At the start of every code block, and after reset, a sweep writes the starting state into every entry of the 32-entry context store, one entry per clock. While the sweep runs, `busy` is high and no input is taken. Requests use a valid/ready handshake. The block handles one request at a time: a request is accepted in one cycle, and its result appears as a one-cycle pulse two clock edges later.

Top module: `ctx_prob_mgr`

## Requirements
- R1: After reset is released, or after a `blk_start` pulse, `busy` stays high for exactly 32 rising edges, and `in_ready` is low the whole time.
- R2: When the sweep ends, every context has MPS 0. The state index is 4 for context 0, 46 for context 17, 3 for context 18, and 0 for every other context, including the unused numbers 19 to 31.
- R3: A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` then drops. `out_valid` is high for exactly one cycle, after the second rising edge following the accepting edge, and `in_ready` is high again in that same cycle.
- R4: With each result, `out_mps` and `out_index` report the context's state from before the update, and `out_qe` is the table's probability estimate for that index.
- R5: `out_mps_event` is 1 when `in_bit` equals the stored MPS, and 0 otherwise (an LPS event).
- R6: On an LPS event the context's index becomes the table's next-on-LPS value. Its MPS is inverted exactly when the row's swap flag is 1. `out_renorm` is 1.
- R7: On an MPS event where `in_areg` minus the estimate is below 0x8000, the index becomes the next-on-MPS value, the MPS is kept, and `out_renorm` is 1.
- R8: On an MPS event where `in_areg` minus the estimate is 0x8000 or more, the context state is unchanged and `out_renorm` is 0.
- R9: An update changes only the addressed context. All other contexts keep their states.
- R10: A `blk_start` pulse restarts the sweep even when a request is in flight. The aborted request produces no `out_valid` and leaves no state behind, and `in_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the sweep |
| blk_start | input | 1 | Code-block start pulse; restarts the sweep |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_cx | input | 5 | Context number |
| in_bit | input | 1 | Decision bit to code |
| in_areg | input | 16 | Current interval register value |
| busy | output | 1 | Context sweep in progress |
| out_valid | output | 1 | Result pulse |
| out_qe | output | 16 | Probability estimate of the pre-update state |
| out_mps | output | 1 | MPS before the update |
| out_index | output | 6 | State index before the update |
| out_mps_event | output | 1 | 1 for an MPS event, 0 for an LPS event |
| out_renorm | output | 1 | Interval must renormalize |

## Verification
The bench reads every context's starting state back through ordinary requests. A wrong starting value, or a sweep that stops short, therefore shows up as a wrong reported index. A long mixed run mostly keeps each context on its own track, so every update path gets exercised:
- LPS steps through swap rows, where an inverted or missing MPS flip changes the sense of later events.
- Renormalizing and non-renormalizing MPS steps, where using the wrong next-state column or advancing on the quiet path drifts the index away from the model.
- Back-to-back requests, where a write landing on a neighbouring context or on the wrong edge corrupts later reads.

A `blk_start` pulse in the middle of a request checks that no stray result or write slips out. Holding `in_valid` high during the sweep checks that nothing is accepted early.

// File: rtl/ctx_pm_pkg.sv
package ctx_pm_pkg;
  localparam int IDX_W    = 6;
  localparam int QE_W     = 16;
  localparam int N_STATES = 47;

  typedef struct packed {
    logic             mps;
    logic [IDX_W-1:0] idx;
  } ctx_state_t;

  typedef struct packed {
    logic [QE_W-1:0]  qe;
    logic [IDX_W-1:0] nmps;
    logic [IDX_W-1:0] nlps;
    logic             swap;
  } trans_t;

  typedef enum logic [1:0] {PH_CLR, PH_IDLE, PH_RD, PH_UPD} phase_t;

  function automatic trans_t mk_row(logic [QE_W-1:0] q, int nm, int nl, logic sw);
    trans_t r;
    r.qe   = q;
    r.nmps = IDX_W'(nm);
    r.nlps = IDX_W'(nl);
    r.swap = sw;
    return r;
  endfunction

  function automatic trans_t trans_lookup(logic [IDX_W-1:0] i);
    case (i)
      6'd0:  return mk_row(16'h5601,  1,  1, 1'b1);
      6'd1:  return mk_row(16'h3401,  2,  6, 1'b0);
      6'd2:  return mk_row(16'h1801,  3,  9, 1'b0);
      6'd3:  return mk_row(16'h0AC1,  4, 12, 1'b0);
      6'd4:  return mk_row(16'h0521,  5, 29, 1'b0);
      6'd5:  return mk_row(16'h0221, 38, 33, 1'b0);
      6'd6:  return mk_row(16'h5601,  7,  6, 1'b1);
      6'd7:  return mk_row(16'h5401,  8, 14, 1'b0);
      6'd8:  return mk_row(16'h4801,  9, 14, 1'b0);
      6'd9:  return mk_row(16'h3801, 10, 14, 1'b0);
      6'd10: return mk_row(16'h3001, 11, 17, 1'b0);
      6'd11: return mk_row(16'h2401, 12, 18, 1'b0);
      6'd12: return mk_row(16'h1C01, 13, 20, 1'b0);
      6'd13: return mk_row(16'h1601, 29, 21, 1'b0);
      6'd14: return mk_row(16'h5601, 15, 14, 1'b1);
      6'd15: return mk_row(16'h5401, 16, 14, 1'b0);
      6'd16: return mk_row(16'h5101, 17, 15, 1'b0);
      6'd17: return mk_row(16'h4801, 18, 16, 1'b0);
      6'd18: return mk_row(16'h3801, 19, 17, 1'b0);
      6'd19: return mk_row(16'h3401, 20, 18, 1'b0);
      6'd20: return mk_row(16'h3001, 21, 19, 1'b0);
      6'd21: return mk_row(16'h2801, 22, 19, 1'b0);
      6'd22: return mk_row(16'h2401, 23, 20, 1'b0);
      6'd23: return mk_row(16'h2201, 24, 21, 1'b0);
      6'd24: return mk_row(16'h1C01, 25, 22, 1'b0);
      6'd25: return mk_row(16'h1801, 26, 23, 1'b0);
      6'd26: return mk_row(16'h1601, 27, 24, 1'b0);
      6'd27: return mk_row(16'h1401, 28, 25, 1'b0);
      6'd28: return mk_row(16'h1201, 29, 26, 1'b0);
      6'd29: return mk_row(16'h1101, 30, 27, 1'b0);
      6'd30: return mk_row(16'h0AC1, 31, 28, 1'b0);
      6'd31: return mk_row(16'h09C1, 32, 29, 1'b0);
      6'd32: return mk_row(16'h08A1, 33, 30, 1'b0);
      6'd33: return mk_row(16'h0521, 34, 31, 1'b0);
      6'd34: return mk_row(16'h0441, 35, 32, 1'b0);
      6'd35: return mk_row(16'h02A1, 36, 33, 1'b0);
      6'd36: return mk_row(16'h0221, 37, 34, 1'b0);
      6'd37: return mk_row(16'h0141, 38, 35, 1'b0);
      6'd38: return mk_row(16'h0111, 39, 36, 1'b0);
      6'd39: return mk_row(16'h0085, 40, 37, 1'b0);
      6'd40: return mk_row(16'h0049, 41, 38, 1'b0);
      6'd41: return mk_row(16'h0025, 42, 39, 1'b0);
      6'd42: return mk_row(16'h0015, 43, 40, 1'b0);
      6'd43: return mk_row(16'h0009, 44, 41, 1'b0);
      6'd44: return mk_row(16'h0005, 45, 42, 1'b0);
      6'd45: return mk_row(16'h0001, 45, 43, 1'b0);
      default: return mk_row(16'h5601, 46, 46, 1'b0);
    endcase
  endfunction

  function automatic ctx_state_t start_state(int unsigned cx);
    ctx_state_t s;
    s.mps = 1'b0;
    case (cx)
      0:       s.idx = IDX_W'(4);
      17:      s.idx = IDX_W'(46);
      18:      s.idx = IDX_W'(3);
      default: s.idx = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/ctx_state_ram.sv
module ctx_state_ram
  import ctx_pm_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  ctx_state_t    wdata,
  input  logic [AW-1:0] raddr,
  output ctx_state_t    rdata
);
  localparam int DEPTH = 1 << AW;

  ctx_state_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ctx_trans_rom.sv
module ctx_trans_rom
  import ctx_pm_pkg::*;
(
  input  logic             clk,
  input  logic [IDX_W-1:0] addr,
  output trans_t           row
);
  always_ff @(posedge clk) begin
    row <= trans_lookup(addr);
  end
endmodule

// File: rtl/ctx_clear_seq.sv
module ctx_clear_seq
  import ctx_pm_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          restart,
  input  logic          active,
  output logic [AW-1:0] waddr,
  output ctx_state_t    wdata,
  output logic          last
);
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (restart)     cnt <= '0;
    else if (active) cnt <= cnt + 1'b1;
  end

  assign waddr = cnt;
  assign wdata = start_state(32'(cnt));
  assign last  = (cnt == AW'(DEPTH - 1));
endmodule

// File: rtl/ctx_prob_mgr.sv
module ctx_prob_mgr
  import ctx_pm_pkg::*;
#(
  parameter int CX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blk_start,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CX_W-1:0]  in_cx,
  input  logic             in_bit,
  input  logic [QE_W-1:0]  in_areg,
  output logic             busy,
  output logic             out_valid,
  output logic [QE_W-1:0]  out_qe,
  output logic             out_mps,
  output logic [IDX_W-1:0] out_index,
  output logic             out_mps_event,
  output logic             out_renorm
);
  localparam logic [QE_W-1:0] HALF = QE_W'(1) << (QE_W - 1);

  phase_t          ph;
  logic [CX_W-1:0] cx_q;
  logic            bit_q;
  logic [QE_W-1:0] a_q;

  ctx_state_t      rd_st, nxt_st, clr_data, wr_data;
  trans_t          row;
  logic [CX_W-1:0] clr_addr, rd_addr, wr_addr;
  logic            clr_last, wr_en, accept;
  logic            mps_evt, mps_renorm;
  logic [QE_W-1:0] a_rem;

  assign accept   = (ph == PH_IDLE) && in_valid && !blk_start;
  assign in_ready = (ph == PH_IDLE);
  assign busy     = (ph == PH_CLR);

  // sequencing: sweep, idle, read state, update
  always_ff @(posedge clk) begin
    if (rst || blk_start) begin
      ph <= PH_CLR;
    end else begin
      case (ph)
        PH_CLR:  if (clr_last) ph <= PH_IDLE;
        PH_IDLE: if (in_valid) ph <= PH_RD;
        PH_RD:   ph <= PH_UPD;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      cx_q  <= in_cx;
      bit_q <= in_bit;
      a_q   <= in_areg;
    end
  end

  ctx_clear_seq #(.AW(CX_W)) u_clr (
    .clk     (clk),
    .restart (rst || blk_start),
    .active  (ph == PH_CLR),
    .waddr   (clr_addr),
    .wdata   (clr_data),
    .last    (clr_last)
  );

  assign rd_addr = (ph == PH_IDLE) ? in_cx : cx_q;

  ctx_state_ram #(.AW(CX_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_st)
  );

  ctx_trans_rom u_rom (
    .clk  (clk),
    .addr (rd_st.idx),
    .row  (row)
  );

  // adaptation decision
  always_comb begin
    a_rem      = a_q - row.qe;
    mps_evt    = (bit_q == rd_st.mps);
    mps_renorm = (a_rem < HALF);
    nxt_st     = rd_st;
    if (!mps_evt) begin
      nxt_st.idx = row.nlps;
      nxt_st.mps = rd_st.mps ^ row.swap;
    end else if (mps_renorm) begin
      nxt_st.idx = row.nmps;
    end
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = clr_addr;
    wr_data = clr_data;
    if (ph == PH_CLR) begin
      wr_en = 1'b1;
    end else if (ph == PH_UPD && !blk_start) begin
      wr_en   = 1'b1;
      wr_addr = cx_q;
      wr_data = nxt_st;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= (ph == PH_UPD) && !blk_start;
    if (ph == PH_UPD) begin
      out_qe        <= row.qe;
      out_mps       <= rd_st.mps;
      out_index     <= rd_st.idx;
      out_mps_event <= mps_evt;
      out_renorm    <= !mps_evt || mps_renorm;
    end
  end

  // R1: never ready while sweeping
  a_r1_no_ready_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !in_ready);
  // R3: result is a single-cycle pulse
  a_r3_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R3: acceptance closes the door until the result
  a_r3_accept_drops_ready: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !blk_start) |=> !in_ready);
  // R6: written-back index stays inside the table
  a_r6_next_legal: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_UPD) |-> (nxt_st.idx < IDX_W'(N_STATES)));
  // R10: block start always enters the sweep
  a_r10_start_busy: assert property (@(posedge clk) disable iff (rst)
    blk_start |=> busy);
endmodule

// File: tb/tb_ctx_prob_mgr.sv
module tb_ctx_prob_mgr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        blk_start = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_cx = '0;
  logic        in_bit = 1'b0;
  logic [15:0] in_areg = 16'hFFFF;
  logic        busy, out_valid, out_mps, out_mps_event, out_renorm;
  logic [15:0] out_qe;
  logic [5:0]  out_index;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic       ref_mps [32];
  logic [5:0] ref_idx [32];

  always #2 clk = ~clk;

  ctx_prob_mgr dut (
    .clk(clk), .rst(rst), .blk_start(blk_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_cx(in_cx), .in_bit(in_bit), .in_areg(in_areg),
    .busy(busy), .out_valid(out_valid), .out_qe(out_qe), .out_mps(out_mps),
    .out_index(out_index), .out_mps_event(out_mps_event), .out_renorm(out_renorm)
  );

  function automatic logic [28:0] tbl(int i);
    case (i)
      0: tbl={16'h5601,6'd1,6'd1,1'b1};   1: tbl={16'h3401,6'd2,6'd6,1'b0};
      2: tbl={16'h1801,6'd3,6'd9,1'b0};   3: tbl={16'h0AC1,6'd4,6'd12,1'b0};
      4: tbl={16'h0521,6'd5,6'd29,1'b0};  5: tbl={16'h0221,6'd38,6'd33,1'b0};
      6: tbl={16'h5601,6'd7,6'd6,1'b1};   7: tbl={16'h5401,6'd8,6'd14,1'b0};
      8: tbl={16'h4801,6'd9,6'd14,1'b0};  9: tbl={16'h3801,6'd10,6'd14,1'b0};
      10: tbl={16'h3001,6'd11,6'd17,1'b0}; 11: tbl={16'h2401,6'd12,6'd18,1'b0};
      12: tbl={16'h1C01,6'd13,6'd20,1'b0}; 13: tbl={16'h1601,6'd29,6'd21,1'b0};
      14: tbl={16'h5601,6'd15,6'd14,1'b1}; 15: tbl={16'h5401,6'd16,6'd14,1'b0};
      16: tbl={16'h5101,6'd17,6'd15,1'b0}; 17: tbl={16'h4801,6'd18,6'd16,1'b0};
      18: tbl={16'h3801,6'd19,6'd17,1'b0}; 19: tbl={16'h3401,6'd20,6'd18,1'b0};
      20: tbl={16'h3001,6'd21,6'd19,1'b0}; 21: tbl={16'h2801,6'd22,6'd19,1'b0};
      22: tbl={16'h2401,6'd23,6'd20,1'b0}; 23: tbl={16'h2201,6'd24,6'd21,1'b0};
      24: tbl={16'h1C01,6'd25,6'd22,1'b0}; 25: tbl={16'h1801,6'd26,6'd23,1'b0};
      26: tbl={16'h1601,6'd27,6'd24,1'b0}; 27: tbl={16'h1401,6'd28,6'd25,1'b0};
      28: tbl={16'h1201,6'd29,6'd26,1'b0}; 29: tbl={16'h1101,6'd30,6'd27,1'b0};
      30: tbl={16'h0AC1,6'd31,6'd28,1'b0}; 31: tbl={16'h09C1,6'd32,6'd29,1'b0};
      32: tbl={16'h08A1,6'd33,6'd30,1'b0}; 33: tbl={16'h0521,6'd34,6'd31,1'b0};
      34: tbl={16'h0441,6'd35,6'd32,1'b0}; 35: tbl={16'h02A1,6'd36,6'd33,1'b0};
      36: tbl={16'h0221,6'd37,6'd34,1'b0}; 37: tbl={16'h0141,6'd38,6'd35,1'b0};
      38: tbl={16'h0111,6'd39,6'd36,1'b0}; 39: tbl={16'h0085,6'd40,6'd37,1'b0};
      40: tbl={16'h0049,6'd41,6'd38,1'b0}; 41: tbl={16'h0025,6'd42,6'd39,1'b0};
      42: tbl={16'h0015,6'd43,6'd40,1'b0}; 43: tbl={16'h0009,6'd44,6'd41,1'b0};
      44: tbl={16'h0005,6'd45,6'd42,1'b0}; 45: tbl={16'h0001,6'd45,6'd43,1'b0};
      default: tbl={16'h5601,6'd46,6'd46,1'b0};
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ref_init();
    for (int c = 0; c < 32; c++) begin
      ref_mps[c] = 1'b0;
      ref_idx[c] = (c == 0) ? 6'd4 : (c == 17) ? 6'd46 : (c == 18) ? 6'd3 : 6'd0;
    end
  endtask

  task automatic wait_sweep(string req);
    int n = 0;
    bit leak = 0;
    while (busy) begin
      if (in_ready || out_valid) leak = 1;
      @(negedge clk);
      n++;
    end
    in_valid = 1'b0;
    chk(n == 32, req, n, 32);
    chk(!leak, req, leak, 0);
  endtask

  // one request; tag names the requirement the update path exercises
  task automatic do_op(int cx, bit b, logic [15:0] a, string tag);
    logic [28:0] e;
    bit evt, rn;
    logic [15:0] rem;
    while (!in_ready) @(negedge clk);
    e = tbl(int'(ref_idx[cx]));
    evt = (b == ref_mps[cx]);
    rem = a - e[28:13];
    rn = !evt || (rem < 16'h8000);
    in_valid = 1'b1; in_cx = 5'(cx); in_bit = b; in_areg = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready && !out_valid, "R3", {in_ready, out_valid}, 0);
    @(negedge clk);
    chk(!out_valid, "R3", out_valid, 0);
    @(negedge clk);
    chk(out_valid && in_ready, "R3", {out_valid, in_ready}, 3);
    chk(out_index == ref_idx[cx] && out_mps == ref_mps[cx], tag,
        {out_mps, out_index}, {ref_mps[cx], ref_idx[cx]});
    chk(out_qe == e[28:13], "R4", out_qe, e[28:13]);
    chk(out_mps_event == evt, "R5", out_mps_event, evt);
    chk(out_renorm == rn, evt ? (rn ? "R7" : "R8") : "R6", out_renorm, rn);
    if (!evt) begin
      ref_idx[cx] = e[6:1];
      ref_mps[cx] = ref_mps[cx] ^ e[0];
    end else if (rn) begin
      ref_idx[cx] = e[12:7];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    ref_init();
    repeat (3) @(negedge clk);
    chk(busy && !in_ready && !out_valid, "R1", {busy, in_ready, out_valid}, 4);
    rst = 1'b0;
    wait_sweep("R1");

    // R2: read back every starting state with a quiet MPS request
    for (int c = 0; c < 32; c++) do_op(c, 1'b0, 16'hFFFF, "R2");

    // R6: repeated LPS on one context walks swap rows
    for (int k = 0; k < 12; k++) do_op(5, ~ref_mps[5], 16'hFFFF, "R6");
    // R7: renormalizing MPS climbs the next-on-MPS column
    for (int k = 0; k < 50; k++) do_op(7, ref_mps[7], 16'h8000, "R7");
    // R8: quiet MPS keeps the state
    for (int k = 0; k < 5; k++) do_op(7, ref_mps[7], 16'hFFFF, "R8");

    // R9: mixed traffic across all contexts
    for (int k = 0; k < 3000; k++) begin
      int c = int'($urandom_range(0, 18));
      int s = int'($urandom_range(0, 3));
      logic [15:0] a = (s == 0) ? 16'h8000 : (s == 1) ? 16'hFFFF : (16'h8000 | 16'($urandom));
      do_op(c, 1'($urandom), a, "R9");
    end

    // R10: in_valid held through a sweep is ignored
    @(negedge clk);
    blk_start = 1'b1; in_valid = 1'b1; in_cx = 5'd3; in_bit = 1'b1;
    @(negedge clk);
    blk_start = 1'b0;
    ref_init();
    wait_sweep("R10");
    for (int c = 0; c < 19; c++) do_op(c, 1'b0, 16'hFFFF, "R10");

    // R10: abort an in-flight LPS request
    do_op(2, 1'b1, 16'h8000, "R9");
    in_valid = 1'b1; in_cx = 5'd0; in_bit = 1'b1; in_areg = 16'h8000;
    @(negedge clk);
    in_valid = 1'b0;
    blk_start = 1'b1;
    @(negedge clk);
    blk_start = 1'b0;
    chk(busy && !out_valid, "R10", {busy, out_valid}, 2);
    ref_init();
    wait_sweep("R10");
    do_op(0, 1'b0, 16'hFFFF, "R10");
    do_op(2, 1'b0, 16'hFFFF, "R2");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule